// File: doc/BRIEF.md
# Three-Bit Pseudo-Random Sequence Generator

This block is a small pattern source for built-in self-test. It is a three-stage linear feedback shift register. On every clock where the advance input is high, the register shifts one place toward its most significant bit. The new least significant bit is the XOR of two state bits. Starting from all ones, the state passes through each of the seven nonzero three-bit codes once, then starts over. A one-cycle wrap pulse marks the step that brings the state back to its starting code, so a signature collector can close one window and open the next.

The register moves through seven named states, shown here as `y[2:0]`:

| State | Code |
|-------|------|
| S_SEED | 111 |
| S_B | 110 |
| S_C | 101 |
| S_D | 010 |
| S_E | 100 |
| S_F | 001 |
| S_G | 011 |

The transitions are:
- Each enabled clock moves to the next state: S_SEED→S_B→S_C→S_D→S_E→S_F→S_G.
- The step S_G→S_SEED is the wrap transition.
- An idle clock keeps the current state.
- Reset leads to S_SEED from any state.

The code 000 is a dead state. Reset can never reach it. If the register were ever upset into 000, it would stay there, because XOR feedback of zeros gives zero. This is a known property and the block does not correct it.

Top module: `prsg3_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `y` = 3'b111 and `wrap` = 0.
- R2: On each clock with `adv` high and `rst` low, the new `y` is the old `y` shifted left. `y[2]` takes the old `y[1]`, `y[1]` takes the old `y[0]`, and `y[0]` takes the old `y[2]` XOR the old `y[0]`.
- R3: Counted from reset, successive enabled clocks give exactly 111, 110, 101, 010, 100, 001, 011, 111, and so on.
- R4: The period is 7. Every nonzero three-bit code appears exactly once in any seven consecutive enabled states.
- R5: On a clock with `adv` low and `rst` low, `y` keeps its value and `wrap` is 0 in the next cycle.
- R6: `wrap` is high for exactly the one cycle after an enabled clock that moved `y` from 011 to 111. It is low in every other cycle.
- R7: Reset is synchronous and wins over `adv`. A clock with both `rst` and `adv` high gives 111 and `wrap` = 0, not a step.
- R8: After reset, `y` never equals 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, loads all ones |
| adv | input | 1 | Advance enable; high steps the sequence, low holds it |
| y | output | 3 | Current pseudo-random state |
| wrap | output | 1 | One-cycle pulse when the state returns to 111 by an enabled step |

## Verification
The assertions check these behaviours on every cycle:
- the reset value (R1),
- the hold on idle clocks (R5),
- the shift-and-feedback relation of each enabled step (R2),
- the absence of 000 (R8),
- that `wrap` lasts one cycle and appears only together with 111 (R6).

The exact seven-step order and the period are properties of whole runs, so only the bench scenarios can show them:
- several full periods driven back to back,
- enable patterns with gaps,
- a reset in the middle of a sequence while `adv` is high.

// File: rtl/prsg3_pkg.sv
package prsg3_pkg;
    localparam int STAGES   = 3;
    localparam int TAP_HI   = 2;
    localparam int TAP_LO   = 0;
    localparam int PERIOD   = (1 << STAGES) - 1;
    typedef logic [STAGES-1:0] prsg_state_t;
    localparam prsg_state_t SEED = '1;
endpackage

// File: rtl/prsg3_feedback.sv
module prsg3_feedback
    import prsg3_pkg::*;
(
    input  prsg_state_t cur,
    output prsg_state_t nxt
);
    // Left shift: each stage takes its lower neighbour.
    for (genvar gi = 1; gi < STAGES; gi++) begin : g_shift
        assign nxt[gi] = cur[gi-1];
    end
    // The incoming bit is the XOR of the two taps.
    assign nxt[0] = cur[TAP_HI] ^ cur[TAP_LO];
endmodule

// File: rtl/prsg3_wrap_detect.sv
module prsg3_wrap_detect
    import prsg3_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  prsg_state_t nxt,
    output logic        wrap
);
    logic hit;

    always_comb begin
        hit = step && (nxt == SEED);
    end

    always_ff @(posedge clk) begin
        if (rst) wrap <= 1'b0;
        else     wrap <= hit;
    end

    // R6: the pulse never lasts longer than one cycle.
    p_wrap_single_r6: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !wrap);
endmodule

// File: rtl/prsg3_top.sv
module prsg3_top
    import prsg3_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    output logic [2:0] y,
    output logic       wrap
);
    prsg_state_t state_q;
    prsg_state_t state_nxt;

    prsg3_feedback i_fb (
        .cur (state_q),
        .nxt (state_nxt)
    );

    prsg3_wrap_detect i_wrap (
        .clk  (clk),
        .rst  (rst),
        .step (adv),
        .nxt  (state_nxt),
        .wrap (wrap)
    );

    // State register: reset wins, then advance, otherwise hold.
    always_ff @(posedge clk) begin
        if (rst)      state_q <= SEED;
        else if (adv) state_q <= state_nxt;
    end

    always_comb begin
        y = state_q;
    end

    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (y == 3'b111 && !wrap));
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(y) && !wrap));
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        adv |=> (y[2] == $past(y[1]) && y[1] == $past(y[0])
                 && y[0] == ($past(y[2]) ^ $past(y[0]))));
    p_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        y != 3'b000);
    p_wrap_seed_r6: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (y == 3'b111));
endmodule

// File: tb/test_prsg3_top.sv
`timescale 1ns/1ps
module test_prsg3_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv = 1'b0;
    logic [2:0] y;
    logic       wrap;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int         idx;       // position in expected order
    logic [2:0] exp_y;
    logic       exp_w;

    always #2 clk = ~clk;  // 250 MHz

    prsg3_top i_prsg3_top (.clk(clk), .rst(rst), .adv(adv), .y(y), .wrap(wrap));

    function automatic logic [2:0] order_at(int k);
        case (k)
            0: return 3'b111;
            1: return 3'b110;
            2: return 3'b101;
            3: return 3'b010;
            4: return 3'b100;
            5: return 3'b001;
            default: return 3'b011;
        endcase
    endfunction

    task automatic check(string req, logic [2:0] ay, logic [2:0] ey, logic aw, logic ew);
        checks++;
        if (ay !== ey || aw !== ew) begin
            errors++;
            $display("FAIL %s: y=%b wrap=%b expected y=%b wrap=%b", req, ay, aw, ey, ew);
        end
    endtask

    // One clock: drive away from the edge, sample after it.
    task automatic tick(logic r, logic a);
        @(negedge clk);
        rst = r;
        adv = a;
        @(posedge clk);
        #1;
    endtask

    task automatic do_step(logic a, string req);
        tick(1'b0, a);
        if (a) begin
            idx   = (idx + 1) % 7;
            exp_w = (idx == 0);
        end else begin
            exp_w = 1'b0;
        end
        exp_y = order_at(idx);
        check(req, y, exp_y, wrap, exp_w);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: y=%b wrap=%b expected finish", y, wrap);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] seen;
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        idx = 0;
        check("R1 reset", y, 3'b111, wrap, 1'b0);

        // R3/R6: three full periods with continuous advance.
        for (int k = 0; k < 21; k++) do_step(1'b1, "R3 order/R6 wrap");

        // R4: one period covers every nonzero code once.
        seen = '0;
        for (int k = 0; k < 7; k++) begin
            do_step(1'b1, "R4 period");
            seen[y] = 1'b1;
        end
        checks++;
        if (seen !== 8'b1111_1110) begin
            errors++;
            $display("FAIL R4 coverage: seen=%b expected %b", seen, 8'b1111_1110);
        end

        // R5/R2: gapped enable patterns.
        for (int k = 0; k < 40; k++) do_step((k % 3) != 0, "R5 hold/R2 step");
        for (int k = 0; k < 30; k++) do_step((k % 4) < 2, "R5 hold/R6 wrap");

        // R7: reset while advancing, from the middle of the sequence.
        do_step(1'b1, "R2 step");
        do_step(1'b1, "R2 step");
        tick(1'b1, 1'b1);
        idx = 0;
        check("R7 reset priority", y, 3'b111, wrap, 1'b0);

        // R6: wrap right after reset through a full period, then hold.
        for (int k = 0; k < 7; k++) do_step(1'b1, "R6 wrap after reset");
        do_step(1'b0, "R6 wrap one cycle");

        // R8: keep running and confirm never zero.
        for (int k = 0; k < 50; k++) begin
            do_step(1'b1, "R3 order");
            checks++;
            if (y === 3'b000) begin
                errors++;
                $display("FAIL R8 zero: y=%b expected nonzero", y);
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule